// File: doc/BRIEF.md
# Segmented Memory Window Decoder

This block decides whether a host bus address belongs to the downstream memory window of a bridge. The window lies in the top 256 MB of a 32-bit address space (address bits 31:28 all ones). That region is cut into 32 slices of 8 MB each. A 32-bit slice-enable register holds one bit per slice. Setting a bit claims that slice for the bridge. There is no base/limit pair, so any mix of slices can be claimed.

For every host address the block reports a hit, a downstream address and the bounds of the contiguous run of enabled slices that holds the address. Neighbouring enabled slices merge into one run. The hit path is purely combinational from the address and the register. A register write takes effect at the next clock edge. Accesses flagged as I/O port space are never claimed, whatever the register holds. The block only decodes. Forwarding the transaction is left to the logic around it.

Top module: `mmio_window_decoder`

## Requirements
- R1: After reset the slice-enable register reads 0 on `slice_map` and no address produces `hit`.
- R2: A write with `cfg_wr`=1 and `cfg_off`=0x060 updates the register at the next rising clock edge. Byte `b` of `cfg_wdata` (bits 8b+7:8b) is taken only when `cfg_be[b]` is 1; the other bytes keep their old value.
- R3: A write with `cfg_off` other than 0x060 leaves the register unchanged.
- R4: `hit` is 1 exactly when `host_io`=0, `host_addr[31:28]`=4'hF and register bit `host_addr[27:23]` is 1. Bit i covers 0xF0000000 + i*0x00800000 up to 8 MB later.
- R5: With `host_io`=1, `hit` is 0 and `down_addr` is 0.
- R6: On a hit, `down_addr` equals `host_addr`; otherwise it is 0.
- R7: On a hit, `win_base` is the first byte and `win_limit` the last byte of the longest run of adjacent enabled slices containing the hit slice; both are 0 without a hit.
- R8: Addresses with bits 31:28 other than 4'hF never hit, even with all 32 bits enabled.
- R9: Driving `rst_n` low clears the register at once, without waiting for a clock edge; release is taken in on the clock through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_off | input | 12 | Register offset of the write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| slice_map | output | 32 | Current slice-enable register |
| host_addr | input | 32 | Host bus address to decode |
| host_io | input | 1 | 1 when the access targets I/O port space |
| hit | output | 1 | Address claimed by an enabled slice |
| down_addr | output | 32 | Downstream address (pass-through on hit) |
| win_base | output | 32 | First byte of the enabled run holding the hit |
| win_limit | output | 32 | Last byte of the enabled run holding the hit |

## Verification
The register checks assume that no write is issued while the internal synchronised reset is still low, that is, in the two clock edges after `rst_n` rises. The bench therefore waits four cycles after every reset release before it issues the first write. The combinational checks assume that `host_addr` and `host_io` are stable around the sampling edge. The bench changes them only on falling edges and samples outputs a delay later, well away from the rising edge.

// File: rtl/mmio_window_pkg.sv
package mmio_window_pkg;

  // Outcome of classifying one host access.
  typedef enum logic [1:0] {
    CLS_OUTSIDE = 2'd0,  // address not in the windowed region
    CLS_IOSPACE = 2'd1,  // I/O port access, never claimed
    CLS_OFF     = 2'd2,  // in region, slice not enabled
    CLS_HIT     = 2'd3   // in region, slice enabled
  } access_cls_e;

  localparam int unsigned DEF_ADDR_W      = 32;
  localparam int unsigned DEF_SLICE_SHIFT = 23;
  localparam int unsigned DEF_SLICES      = 32;
  localparam int unsigned DEF_OFF_W       = 12;

endpackage

// File: rtl/mwd_reset_sync.sv
module mwd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mwd_slice_map.sv
module mwd_slice_map #(
  parameter int unsigned SLICES     = 32,
  parameter int unsigned OFF_W      = 12,
  parameter logic [OFF_W-1:0] MAP_OFF = 12'h060,
  localparam int unsigned LANES     = (SLICES + 7) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [OFF_W-1:0]  off,
  input  logic [LANES-1:0]  be,
  input  logic [SLICES-1:0] wdata,
  output logic [SLICES-1:0] map
);

  logic              sel;
  logic [SLICES-1:0] bit_en;
  logic [SLICES-1:0] map_d;
  logic [SLICES-1:0] map_q;

  assign sel = wr && (off == MAP_OFF);

  // Per-bit write enable taken from the byte lane that holds the bit.
  for (genvar i = 0; i < SLICES; i++) begin : g_bit
    assign bit_en[i] = sel && be[i / 8];
  end

  always_comb begin
    for (int i = 0; i < SLICES; i++) begin
      map_d[i] = bit_en[i] ? wdata[i] : map_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
    end else if (sel) begin
      map_q <= map_d;
    end
  end

  assign map = map_q;

endmodule

// File: rtl/mwd_slice_decode.sv
module mwd_slice_decode
  import mmio_window_pkg::*;
#(
  parameter int unsigned SLICES = 32,
  parameter int unsigned TAG_W  = 4,
  parameter logic [TAG_W-1:0] REGION_TAG = 4'hF,
  localparam int unsigned IDX_W = $clog2(SLICES)
) (
  input  logic [TAG_W-1:0]  tag,
  input  logic [IDX_W-1:0]  idx,
  input  logic              is_io,
  input  logic [SLICES-1:0] map,
  output access_cls_e       cls
);

  always_comb begin
    if (is_io) begin
      cls = CLS_IOSPACE;
    end else if (tag != REGION_TAG) begin
      cls = CLS_OUTSIDE;
    end else if (map[idx]) begin
      cls = CLS_HIT;
    end else begin
      cls = CLS_OFF;
    end
  end

endmodule

// File: rtl/mwd_run_span.sv
module mwd_run_span #(
  parameter int unsigned SLICES = 32,
  localparam int unsigned IDX_W = $clog2(SLICES)
) (
  input  logic [SLICES-1:0] map,
  input  logic [IDX_W-1:0]  idx,
  output logic [IDX_W-1:0]  run_lo,
  output logic [IDX_W-1:0]  run_hi
);

  logic [IDX_W-1:0] lo_of [SLICES];
  logic [IDX_W-1:0] hi_of [SLICES];

  // Lowest slice of the run: walk downward while the lower neighbour is enabled.
  assign lo_of[0] = '0;
  for (genvar i = 1; i < SLICES; i++) begin : g_lo
    assign lo_of[i] = map[i-1] ? lo_of[i-1] : IDX_W'(i);
  end

  // Highest slice of the run: walk upward while the upper neighbour is enabled.
  assign hi_of[SLICES-1] = IDX_W'(SLICES - 1);
  for (genvar i = 0; i < SLICES - 1; i++) begin : g_hi
    assign hi_of[i] = map[i+1] ? hi_of[i+1] : IDX_W'(i);
  end

  assign run_lo = lo_of[idx];
  assign run_hi = hi_of[idx];

endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder
  import mmio_window_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned SLICE_SHIFT = DEF_SLICE_SHIFT,
  parameter int unsigned SLICES      = DEF_SLICES,
  parameter int unsigned OFF_W       = DEF_OFF_W,
  parameter logic [OFF_W-1:0] MAP_OFF = 12'h060,
  localparam int unsigned IDX_W      = $clog2(SLICES),
  localparam int unsigned TAG_W      = ADDR_W - SLICE_SHIFT - IDX_W,
  localparam logic [TAG_W-1:0] REGION_TAG = '1,
  localparam int unsigned LANES      = (SLICES + 7) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [LANES-1:0]  cfg_be,
  input  logic [SLICES-1:0] cfg_wdata,
  output logic [SLICES-1:0] slice_map,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_io,
  output logic              hit,
  output logic [ADDR_W-1:0] down_addr,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_limit
);

  logic             rst_sync_n;
  access_cls_e      cls;
  logic [IDX_W-1:0] run_lo;
  logic [IDX_W-1:0] run_hi;
  logic [TAG_W-1:0] addr_tag;
  logic [IDX_W-1:0] addr_idx;

  assign addr_tag = host_addr[ADDR_W-1 -: TAG_W];
  assign addr_idx = host_addr[SLICE_SHIFT +: IDX_W];

  mwd_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mwd_slice_map #(
    .SLICES (SLICES),
    .OFF_W  (OFF_W),
    .MAP_OFF(MAP_OFF)
  ) u_map (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .wr   (cfg_wr),
    .off  (cfg_off),
    .be   (cfg_be),
    .wdata(cfg_wdata),
    .map  (slice_map)
  );

  mwd_slice_decode #(
    .SLICES    (SLICES),
    .TAG_W     (TAG_W),
    .REGION_TAG(REGION_TAG)
  ) u_dec (
    .tag  (addr_tag),
    .idx  (addr_idx),
    .is_io(host_io),
    .map  (slice_map),
    .cls  (cls)
  );

  mwd_run_span #(.SLICES(SLICES)) u_span (
    .map   (slice_map),
    .idx   (addr_idx),
    .run_lo(run_lo),
    .run_hi(run_hi)
  );

  always_comb begin
    hit       = (cls == CLS_HIT);
    down_addr = '0;
    win_base  = '0;
    win_limit = '0;
    if (hit) begin
      down_addr = host_addr;
      win_base  = {REGION_TAG, run_lo, {SLICE_SHIFT{1'b0}}};
      win_limit = {REGION_TAG, run_hi, {SLICE_SHIFT{1'b1}}};
    end
  end

endmodule

// File: rtl/mmio_window_decoder_chk.sv
module mmio_window_decoder_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SLICES = 32,
  parameter int unsigned OFF_W  = 12,
  parameter logic [OFF_W-1:0] MAP_OFF = 12'h060,
  localparam int unsigned LANES = (SLICES + 7) / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [OFF_W-1:0]  cfg_off,
  input logic [LANES-1:0]  cfg_be,
  input logic [SLICES-1:0] cfg_wdata,
  input logic [SLICES-1:0] slice_map,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_io,
  input logic              hit,
  input logic [ADDR_W-1:0] down_addr,
  input logic [ADDR_W-1:0] win_base,
  input logic [ADDR_W-1:0] win_limit
);

  a_r1_empty_map_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_map == '0) |-> !hit);

  a_r2_full_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_off == MAP_OFF && cfg_be == '1) |=> (slice_map == $past(cfg_wdata)));

  a_r3_other_offset_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_off == MAP_OFF) |=> $stable(slice_map));

  a_r5_io_never_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    host_io |-> (!hit && down_addr == '0));

  a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (down_addr == host_addr));

  a_r7_addr_inside_run: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (win_base <= host_addr && host_addr <= win_limit));

  a_r8_outside_region: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr[ADDR_W-1 -: 4] != 4'hF) |-> !hit);

endmodule

bind mmio_window_decoder mmio_window_decoder_chk #(
  .ADDR_W (ADDR_W),
  .SLICES (SLICES),
  .OFF_W  (OFF_W),
  .MAP_OFF(MAP_OFF)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_off  (cfg_off),
  .cfg_be   (cfg_be),
  .cfg_wdata(cfg_wdata),
  .slice_map(slice_map),
  .host_addr(host_addr),
  .host_io  (host_io),
  .hit      (hit),
  .down_addr(down_addr),
  .win_base (win_base),
  .win_limit(win_limit)
);

// File: tb/mmio_window_decoder_tb_top.sv
`timescale 1ns/1ps
module mmio_window_decoder_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [11:0] cfg_off;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] slice_map;
  logic [31:0] host_addr;
  logic        host_io;
  logic        hit;
  logic [31:0] down_addr;
  logic [31:0] win_base;
  logic [31:0] win_limit;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model_map;
  bit done = 0;

  mmio_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .slice_map(slice_map),
    .host_addr(host_addr), .host_io(host_io), .hit(hit),
    .down_addr(down_addr), .win_base(win_base), .win_limit(win_limit)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic ref_hit(input logic [31:0] a, input logic io, input logic [31:0] m);
    return !io && a[31:28] == 4'hF && m[a[27:23]];
  endfunction

  task automatic ref_span(input logic [31:0] a, input logic [31:0] m,
                          output logic [31:0] b, output logic [31:0] l);
    int k = int'(a[27:23]);
    int lo = k;
    int hi = k;
    while (lo > 0 && m[lo-1]) lo--;
    while (hi < 31 && m[hi+1]) hi++;
    b = 32'hF000_0000 + 32'(lo) * 32'h0080_0000;
    l = 32'hF000_0000 + 32'(hi + 1) * 32'h0080_0000 - 32'd1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_map = '0;
  endtask

  task automatic do_write(input logic [11:0] off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_off = off; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    if (off == 12'h060)
      for (int b = 0; b < 4; b++)
        if (be[b]) model_map[8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic probe(input logic [31:0] a, input logic io, input string req);
    logic eh;
    logic [31:0] eb, el;
    host_addr = a; host_io = io;
    #1;
    eh = ref_hit(a, io, model_map);
    eb = '0; el = '0;
    if (eh) ref_span(a, model_map, eb, el);
    chk({31'd0, hit}, {31'd0, eh}, req);
    chk(down_addr, eh ? a : 32'd0, "R6");
    chk(win_base, eb, "R7");
    chk(win_limit, el, "R7");
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(slice_map, 32'd0, "R1");
    probe(32'hF000_0000, 0, "R1");
    probe(32'hFFFF_FFFF, 0, "R1");
  endtask

  task automatic t_basic_map();
    do_write(12'h060, 4'hF, 32'h0000_0005);
    chk(slice_map, 32'h0000_0005, "R2");
    probe(32'hF000_1234, 0, "R4");
    probe(32'hF080_0000, 0, "R4");
    probe(32'hF17F_FFFF, 0, "R4");
    probe(32'hF180_0000, 0, "R4");
  endtask

  task automatic t_byte_lane();
    do_write(12'h060, 4'b0010, 32'hFFFF_FFFF);
    chk(slice_map, 32'h0000_FF05, "R2");
    probe(32'hF500_0000, 0, "R7");
    chk(win_base, 32'hF400_0000, "R7");
    chk(win_limit, 32'hF7FF_FFFF, "R7");
  endtask

  task automatic t_wrong_offset();
    do_write(12'h064, 4'hF, 32'h0000_0000);
    chk(slice_map, 32'h0000_FF05, "R3");
    probe(32'hF000_0010, 0, "R3");
  endtask

  task automatic t_io_space();
    probe(32'hF000_0000, 1, "R5");
    chk({31'd0, hit}, 32'd0, "R5");
    chk(down_addr, 32'd0, "R5");
  endtask

  task automatic t_outside();
    do_write(12'h060, 4'hF, 32'hFFFF_FFFF);
    probe(32'hE000_0000, 0, "R8");
    probe(32'h7FFF_FFFC, 0, "R8");
    probe(32'hFFFF_FFFC, 0, "R4");
    chk(win_base, 32'hF000_0000, "R7");
    chk(win_limit, 32'hFFFF_FFFF, "R7");
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    #3;
    rst_n = 0;
    #1;
    chk(slice_map, 32'd0, "R9");
    model_map = '0;
    probe(32'hF080_0000, 0, "R9");
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(slice_map, 32'd0, "R9");
  endtask

  initial begin
    rst_n = 1; cfg_wr = 0; cfg_off = '0; cfg_be = '0; cfg_wdata = '0;
    host_addr = '0; host_io = 0; model_map = '0;
    t_reset_state();
    t_basic_map();
    t_byte_lane();
    t_wrong_offset();
    t_io_space();
    t_outside();
    t_async_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule